// File: doc/BRIEF.md
# E1 Basic Frame Aligner

This block takes a serial 2.048 Mb/s E1 line stream, one bit per clock-enable pulse, and finds where each 256-bit frame begins. It looks for the 7-bit alignment word that timeslot 0 carries in every other frame. It does not trust the first match. It declares alignment only after a three-step confirmation:

1. the alignment word is seen;
2. bit 2 of timeslot 0 in the next frame reads 1;
3. the alignment word appears again exactly 512 bits after the first one.

If step 2 reads 0, the candidate is dropped and the search continues with the next bit.

Once aligned, the block gives the position of each received bit within its frame and a flag that tells frames carrying the alignment word apart from the others. An active-low sync flag and an enable for the downstream multiframe searches show the alignment state. While aligned, the block checks every alignment slot. Three bad words in a row send it back to the search.

Top module: `e1_frame_aligner`

## Requirements
- R1: While and after reset, `sync_n` is 1, `mf_search_en` is 0, and `bit_pos` and `frame_odd` are 0.
- R2: In the search state, every bit position is a possible candidate. A correct alignment word is found at any bit offset from reset.
- R3: If the bit in position 1 of the frame after a candidate (timeslot 0 bit 2) is 0, the candidate is dropped. The search then resumes with the very next bit, so a correct word later in that frame becomes the new candidate.
- R4: `sync_n` falls to 0 on the clock edge that takes in the last bit of the alignment word lying 512 bits after the candidate. This happens only if the bit-2 check read 1.
- R5: If the word at the confirmation slot is wrong, the block returns to the search and `sync_n` stays 1.
- R6: Timeslot 0 bit 1 (frame position 0) has no effect on detection or on confirmation.
- R7: While aligned, `bit_pos` gives the position (0 to 255) of the most recent bit. Position 0 is timeslot 0 bit 1, and the last bit of the alignment word is at position 7. `frame_odd` is 0 in frames carrying the alignment word and 1 in the others.
- R8: While aligned, an alignment slot without the pattern 0011011 counts as a miss, and a correct word clears the count. The third miss in a row sets `sync_n` to 1 on the edge that takes in that word's last bit.
- R9: `mf_search_en` is 1 exactly while `sync_n` is 0.
- R10: While `bit_en` is 0, `rx_bit` is ignored and no output changes.
- R11: The alignment word is 0011011. Its first bit is received at frame position 1 and its last bit at frame position 7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bit_en | input | 1 | Qualifies `rx_bit`: one pulse per line bit |
| rx_bit | input | 1 | Serial line data, in transmission order |
| sync_n | output | 1 | 0 while basic frame alignment is held |
| mf_search_en | output | 1 | Enables the downstream multiframe searches |
| bit_pos | output | 8 | Position of the most recent bit within its frame |
| frame_odd | output | 1 | 1 in frames without the alignment word |

## Verification
The assertions assume the following about the inputs:
- `rx_bit` matters only in cycles where `bit_en` is high.
- Each pulse carries exactly one line bit, in transmission order.
- Reset is released cleanly before the first qualified bit.

The stimulus drives one qualified bit per pulse. In the random trials it inserts idle gaps of random length between pulses. During those gaps it toggles `rx_bit` at random, so the assumption is exercised and not merely respected. Random payload can form false alignment words. The bench's own bit-level model follows them, so that timing is checked on every bit.

// File: rtl/e1fa_pkg.sv
package e1fa_pkg;

  typedef enum logic [1:0] {
    ST_SEARCH = 2'd0,
    ST_NFAS   = 2'd1,
    ST_FAS    = 2'd2,
    ST_LOCK   = 2'd3
  } fa_state_e;

  // Alignment word carried in frame positions 1..7; oldest bit is the MSB.
  localparam int unsigned    FAS_WIDTH = 7;
  localparam logic [6:0]     FAS_WORD  = 7'b0011011;

endpackage

// File: rtl/e1fa_shift.sv
module e1fa_shift
  import e1fa_pkg::*;
#(
  parameter int unsigned       W   = FAS_WIDTH,
  parameter logic [W-1:0]      PAT = FAS_WORD
) (
  input  logic clk,
  input  logic rst_n,
  input  logic bit_en,
  input  logic rx_bit,
  output logic word_hit
);

  logic [W-1:0] win_q;
  logic [W-1:0] win_d;

  function automatic logic [W-1:0] push_bit(input logic [W-1:0] w, input logic b);
    return {w[W-2:0], b};
  endfunction

  function automatic logic is_word(input logic [W-1:0] w);
    return (w == PAT);
  endfunction

  assign win_d    = push_bit(win_q, rx_bit);
  assign word_hit = is_word(win_d);

  // Reset to all ones: PAT starts with 0, so no partial window can match.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      win_q <= '1;
    else if (bit_en) win_q <= win_d;
  end

  assert_window_idle_R10 : assert property (@(posedge clk) disable iff (!rst_n)
    !bit_en |=> $stable(win_q));

endmodule

// File: rtl/e1fa_pos.sv
module e1fa_pos #(
  parameter int unsigned FRAME_BITS = 256,
  parameter int unsigned LOAD_POS   = 7,
  parameter int unsigned PW         = $clog2(FRAME_BITS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bit_en,
  input  logic          load,
  output logic [PW-1:0] pos_q,
  output logic          odd_q,
  output logic [PW-1:0] pos_nx,
  output logic          odd_nx
);

  localparam logic [PW-1:0] LAST = PW'(FRAME_BITS - 1);
  localparam logic [PW-1:0] LDV  = PW'(LOAD_POS);

  function automatic logic [PW:0] step(input logic odd, input logic [PW-1:0] pos);
    if (pos == LAST) return {~odd, {PW{1'b0}}};
    return {odd, pos + PW'(1)};
  endfunction

  assign {odd_nx, pos_nx} = step(odd_q, pos_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos_q <= '0;
      odd_q <= 1'b0;
    end else if (bit_en) begin
      if (load) begin
        pos_q <= LDV;
        odd_q <= 1'b0;
      end else begin
        pos_q <= pos_nx;
        odd_q <= odd_nx;
      end
    end
  end

  assert_load_phase_R7 : assert property (@(posedge clk) disable iff (!rst_n)
    (bit_en && load) |=> (pos_q == LDV && !odd_q));

  assert_advance_R7 : assert property (@(posedge clk) disable iff (!rst_n)
    (bit_en && !load && pos_q != LAST) |=> (pos_q == $past(pos_q) + PW'(1) && $stable(odd_q)));

  assert_wrap_R7 : assert property (@(posedge clk) disable iff (!rst_n)
    (bit_en && !load && pos_q == LAST) |=> (pos_q == '0 && odd_q != $past(odd_q)));

  assert_pos_idle_R10 : assert property (@(posedge clk) disable iff (!rst_n)
    !bit_en |=> ($stable(pos_q) && $stable(odd_q)));

endmodule

// File: rtl/e1fa_ctrl.sv
module e1fa_ctrl
  import e1fa_pkg::*;
#(
  parameter int unsigned FRAME_BITS = 256,
  parameter int unsigned PW         = $clog2(FRAME_BITS),
  parameter int unsigned FAS_END    = FAS_WIDTH,
  parameter int unsigned NFAS_POS   = 1,
  parameter int unsigned LOSS_LIMIT = 3,
  parameter int unsigned MW         = $clog2(LOSS_LIMIT + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bit_en,
  input  logic          rx_bit,
  input  logic          word_hit,
  input  logic [PW-1:0] pos_nx,
  input  logic          odd_nx,
  output logic          load,
  output logic          sync_n
);

  localparam logic [MW-1:0] MISS_TOP = MW'(LOSS_LIMIT - 1);

  fa_state_e     state_q, state_d;
  logic [MW-1:0] miss_q, miss_d;

  // Named events for the assertions.
  logic fas_slot, nfas_slot;
  logic ev_candidate, ev_reject, ev_confirm_bad, ev_acquire, ev_miss, ev_loss;

  function automatic logic [MW-1:0] bump(input logic [MW-1:0] m);
    return m + MW'(1);
  endfunction

  assign fas_slot  = bit_en && !odd_nx && (pos_nx == PW'(FAS_END));
  assign nfas_slot = bit_en &&  odd_nx && (pos_nx == PW'(NFAS_POS));

  assign ev_candidate   = (state_q == ST_SEARCH) && bit_en && word_hit;
  assign ev_reject      = (state_q == ST_NFAS) && nfas_slot && !rx_bit;
  assign ev_confirm_bad = (state_q == ST_FAS) && fas_slot && !word_hit;
  assign ev_acquire     = (state_q == ST_FAS) && fas_slot && word_hit;
  assign ev_miss        = (state_q == ST_LOCK) && fas_slot && !word_hit;
  assign ev_loss        = ev_miss && (miss_q == MISS_TOP);

  assign load = ev_candidate;

  always_comb begin
    state_d = state_q;
    miss_d  = miss_q;
    unique case (state_q)
      ST_SEARCH: if (ev_candidate) state_d = ST_NFAS;
      ST_NFAS:   if (nfas_slot) state_d = rx_bit ? ST_FAS : ST_SEARCH;
      ST_FAS: begin
        if (fas_slot) begin
          state_d = word_hit ? ST_LOCK : ST_SEARCH;
          miss_d  = '0;
        end
      end
      ST_LOCK: begin
        if (fas_slot) begin
          if (word_hit) begin
            miss_d = '0;
          end else if (ev_loss) begin
            miss_d  = '0;
            state_d = ST_SEARCH;
          end else begin
            miss_d = bump(miss_q);
          end
        end
      end
      default: state_d = ST_SEARCH;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_SEARCH;
      miss_q  <= '0;
      sync_n  <= 1'b1;
    end else begin
      state_q <= state_d;
      miss_q  <= miss_d;
      sync_n  <= (state_d != ST_LOCK);
    end
  end

  assert_reject_zero_R3 : assert property (@(posedge clk) disable iff (!rst_n)
    ev_reject |=> (state_q == ST_SEARCH && sync_n));

  assert_acquire_source_R4 : assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sync_n) |-> ($past(state_q) == ST_FAS && $past(word_hit) && $past(fas_slot)));

  assert_confirm_bad_R5 : assert property (@(posedge clk) disable iff (!rst_n)
    ev_confirm_bad |=> (state_q == ST_SEARCH && sync_n));

  assert_loss_count_R8 : assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sync_n) |-> ($past(miss_q) == MISS_TOP && $past(ev_miss)));

  assert_miss_bound_R8 : assert property (@(posedge clk) disable iff (!rst_n)
    miss_q <= MISS_TOP);

  assert_ctrl_idle_R10 : assert property (@(posedge clk) disable iff (!rst_n)
    !bit_en |=> ($stable(state_q) && $stable(sync_n) && $stable(miss_q)));

endmodule

// File: rtl/e1_frame_aligner.sv
module e1_frame_aligner
  import e1fa_pkg::*;
#(
  parameter int unsigned FRAME_BITS = 256,
  parameter int unsigned LOSS_LIMIT = 3,
  parameter int unsigned PW         = $clog2(FRAME_BITS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bit_en,
  input  logic          rx_bit,
  output logic          sync_n,
  output logic          mf_search_en,
  output logic [PW-1:0] bit_pos,
  output logic          frame_odd
);

  logic          word_hit;
  logic          load;
  logic [PW-1:0] pos_nx;
  logic          odd_nx;

  e1fa_shift #(
    .W   (FAS_WIDTH),
    .PAT (FAS_WORD)
  ) u_shift (
    .clk      (clk),
    .rst_n    (rst_n),
    .bit_en   (bit_en),
    .rx_bit   (rx_bit),
    .word_hit (word_hit)
  );

  e1fa_pos #(
    .FRAME_BITS (FRAME_BITS),
    .LOAD_POS   (FAS_WIDTH),
    .PW         (PW)
  ) u_pos (
    .clk    (clk),
    .rst_n  (rst_n),
    .bit_en (bit_en),
    .load   (load),
    .pos_q  (bit_pos),
    .odd_q  (frame_odd),
    .pos_nx (pos_nx),
    .odd_nx (odd_nx)
  );

  e1fa_ctrl #(
    .FRAME_BITS (FRAME_BITS),
    .PW         (PW),
    .FAS_END    (FAS_WIDTH),
    .NFAS_POS   (1),
    .LOSS_LIMIT (LOSS_LIMIT)
  ) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .bit_en   (bit_en),
    .rx_bit   (rx_bit),
    .word_hit (word_hit),
    .pos_nx   (pos_nx),
    .odd_nx   (odd_nx),
    .load     (load),
    .sync_n   (sync_n)
  );

  assign mf_search_en = ~sync_n;

  assert_out_idle_R10 : assert property (@(posedge clk) disable iff (!rst_n)
    !bit_en |=> ($stable(sync_n) && $stable(bit_pos) && $stable(frame_odd)));

endmodule

// File: tb/test_e1_frame_aligner.sv
module test_e1_frame_aligner;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bit_en = 1'b0;
  logic       rx_bit = 1'b0;
  logic       sync_n;
  logic       mf_search_en;
  logic [7:0] bit_pos;
  logic       frame_odd;

  always #5 clk = ~clk;

  e1_frame_aligner i_e1_frame_aligner (
    .clk          (clk),
    .rst_n        (rst_n),
    .bit_en       (bit_en),
    .rx_bit       (rx_bit),
    .sync_n       (sync_n),
    .mf_search_en (mf_search_en),
    .bit_pos      (bit_pos),
    .frame_odd    (frame_odd)
  );

  int total = 0;
  int bad   = 0;
  bit gaps_on = 1'b0;

  // Bench model state: 0 search, 1 await bit 2, 2 await word, 3 aligned.
  int m_st, m_pos, m_hist, m_miss;
  localparam int WORD_VAL = 27; // 0011011 (R11)

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int frame_bit(input bit fas, input bit ok, input bit b0,
                                   input bit b2, input int k, input bit rbit);
    if (k == 0) return int'(b0);
    if (fas && k < 8) return ((WORD_VAL >> (7 - k)) & 1) ^ int'(!ok && k == 4);
    if (!fas && k == 1) return int'(b2);
    if (!fas && k < 8) return 1;
    return int'(rbit);
  endfunction

  task automatic model_reset();
    m_st = 0; m_pos = 0; m_hist = 127; m_miss = 0;
  endtask

  task automatic model_step(input bit b);
    int h, np;
    h  = ((m_hist << 1) | int'(b)) & 127;
    np = (m_pos + 1) % 512;
    case (m_st)
      0: if (h == WORD_VAL) begin m_st = 1; np = 7; end
      1: if (np == 257) m_st = b ? 2 : 0;
      2: if (np == 7) begin m_st = (h == WORD_VAL) ? 3 : 0; m_miss = 0; end
      default: if (np == 7) begin
        if (h == WORD_VAL) m_miss = 0;
        else begin
          m_miss++;
          if (m_miss == 3) begin m_st = 0; m_miss = 0; end
        end
      end
    endcase
    m_hist = h;
    m_pos  = np;
  endtask

  task automatic send_bit(input bit b);
    @(negedge clk);
    bit_en = 1'b1;
    rx_bit = b;
    model_step(b);
    @(negedge clk);
    bit_en = 1'b0;
    chk("R4 R8 sync_n", int'(sync_n), int'(m_st != 3));
    chk("R9 mf_search_en", int'(mf_search_en), int'(m_st == 3));
    if (m_st == 3) begin
      chk("R7 bit_pos", int'(bit_pos), m_pos % 256);
      chk("R7 frame_odd", int'(frame_odd), m_pos / 256);
    end
    if (gaps_on) begin
      int n;
      logic s0, o0;
      logic [7:0] p0;
      n = $urandom % 3;
      s0 = sync_n; p0 = bit_pos; o0 = frame_odd;
      for (int i = 0; i < n; i++) begin
        rx_bit = 1'($urandom);
        @(negedge clk);
      end
      if (n > 0) begin
        chk("R10 idle sync_n", int'(sync_n), int'(s0));
        chk("R10 idle bit_pos", int'(bit_pos), int'(p0));
        chk("R10 idle frame_odd", int'(frame_odd), int'(o0));
      end
    end
  endtask

  task automatic send_frame(input bit fas, input bit ok, input bit b0,
                            input bit b2, input bit rnd);
    for (int k = 0; k < 256; k++) begin
      bit rb;
      rb = rnd ? 1'($urandom) : 1'b0;
      send_bit(1'(frame_bit(fas, ok, b0, b2, k, rb)));
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n  = 1'b0;
    bit_en = 1'b0;
    repeat (3) @(negedge clk);
    model_reset();
    chk("R1 sync_n in reset", int'(sync_n), 1);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 sync_n", int'(sync_n), 1);
    chk("R1 mf_search_en", int'(mf_search_en), 0);
    chk("R1 bit_pos", int'(bit_pos), 0);
    chk("R1 frame_odd", int'(frame_odd), 0);
  endtask

  initial begin
    repeat (199000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int offs[3];
    void'($urandom(32'd4171));
    offs[0] = 0; offs[1] = 129; offs[2] = 255;

    do_reset();

    // R2 R4 R6 R7: lock after 37 idle zero bits; bit 1 set in the first word
    repeat (37) send_bit(1'b0);
    send_frame(1, 1, 1, 0, 0);
    send_frame(0, 1, 0, 1, 0);
    send_frame(1, 1, 0, 0, 0);
    chk("R4 locked", int'(sync_n), 0);
    chk("R7 last pos", int'(bit_pos), 255);
    chk("R7 word frame", int'(frame_odd), 0);
    chk("R9 enabled", int'(mf_search_en), 1);
    send_frame(0, 1, 1, 0, 0);
    send_frame(1, 1, 1, 0, 0);
    chk("R6 bit1 ignored", int'(sync_n), 0);

    // R8: two misses, a good word, then three misses
    send_frame(0, 1, 0, 1, 0); send_frame(1, 0, 0, 0, 0);
    send_frame(0, 1, 0, 1, 0); send_frame(1, 0, 0, 0, 0);
    chk("R8 two misses", int'(sync_n), 0);
    send_frame(0, 1, 0, 1, 0); send_frame(1, 1, 0, 0, 0);
    send_frame(0, 1, 0, 1, 0); send_frame(1, 0, 0, 0, 0);
    send_frame(0, 1, 0, 1, 0); send_frame(1, 0, 0, 0, 0);
    chk("R8 count cleared", int'(sync_n), 0);
    send_frame(0, 1, 0, 1, 0); send_frame(1, 0, 0, 0, 0);
    chk("R8 lost", int'(sync_n), 1);

    // R5: bad confirmation word, then a clean relock
    send_frame(0, 1, 0, 1, 0);
    send_frame(1, 1, 0, 0, 0);
    send_frame(0, 1, 0, 1, 0);
    send_frame(1, 0, 0, 0, 0);
    chk("R5 confirm failed", int'(sync_n), 1);
    send_frame(0, 1, 0, 1, 0);
    send_frame(1, 1, 0, 0, 0);
    send_frame(0, 1, 0, 1, 0);
    send_frame(1, 1, 0, 0, 0);
    chk("R5 relock", int'(sync_n), 0);

    // R3: bit 2 zero rejects; the next word is then the new candidate
    do_reset();
    send_frame(1, 1, 0, 0, 0);
    send_frame(0, 1, 0, 0, 0);
    send_frame(1, 1, 0, 0, 0);
    chk("R3 rejected", int'(sync_n), 1);
    send_frame(0, 1, 0, 1, 0);
    send_frame(1, 1, 0, 0, 0);
    chk("R3 resumed", int'(sync_n), 0);

    // R2 R11: directed offsets from reset
    for (int i = 0; i < 3; i++) begin
      do_reset();
      repeat (offs[i]) send_bit(1'b0);
      send_frame(1, 1, 1'(i), 0, 0);
      send_frame(0, 1, 0, 1, 0);
      send_frame(1, 1, 0, 0, 0);
      chk("R2 offset lock", int'(sync_n), 0);
      chk("R11 word end pos", int'(bit_pos), 255);
    end

    // R2 R10: random offsets, payload, idle gaps and occasional errors
    gaps_on = 1'b1;
    for (int t = 0; t < 4; t++) begin
      int n;
      do_reset();
      n = $urandom % 512;
      for (int i = 0; i < n; i++) send_bit(1'($urandom));
      for (int f = 0; f < 14; f++) begin
        send_frame(f % 2 == 0, ($urandom % 8) != 0, 1'($urandom),
                   ($urandom % 16) != 0, 1'b1);
      end
      chk("R2 random run", int'(sync_n), int'(m_st != 3));
    end
    gaps_on = 1'b0;

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule